// File: doc/BRIEF.md
# Nibble Stack Push/Pop Engine

This block runs the stack operations of a 4-bit processor core. The stack lives in nibble-wide data memory and grows downward, addressed by an 8-bit stack pointer held inside the engine. A single command port accepts one of four operations: push, pop, pointer increment and pointer decrement. A 3-bit selector names the register that a push reads from or that a pop writes to. The selectable registers are the general register, the page and nibble registers of the two index pointers, and the flag register.

A push lowers the pointer first and then stores the selected register's nibble at the new top. A pop reads the top nibble, hands it to its destination, and only then raises the pointer. The flag register is restored through its own load strobe, not through the ordinary register write. Every command occupies the engine for a fixed number of cycles, 5 by default. While it is busy, further commands are ignored. Subroutine call and return sequencing sit elsewhere.

Top module: `stk_engine`

## Requirements
- R1: While `rst` is high at a clock edge, `sp` takes the value of `SP_RESET` (default 0x00) and `busy` goes low. After that edge, `mem_we`, `mem_re`, `rf_we` and `flag_ld` stay low until a command is accepted.
- R2: A command is accepted at a clock edge where `cmd_valid` is high and `busy` is low. `busy` then stays high for exactly `OP_CYCLES` cycles (default 5). Commands presented while `busy` is high have no effect.
- R3: Push (`cmd_op` = 0) works in two steps. In the first busy cycle the engine samples `rf_rdata`, and at the end of that cycle `sp` drops by one. In the second busy cycle, and only there, `mem_we` is high with `mem_addr` equal to the new `sp` and `mem_wdata` equal to the sampled nibble.
- R4: Pop (`cmd_op` = 1) works in three steps. In the first busy cycle `mem_re` is high with `mem_addr` equal to `sp`, and `mem_rdata` is sampled. In the second busy cycle the sampled nibble appears on `rf_wdata` with a write strobe. At the end of the third busy cycle `sp` rises by one.
- R5: A pop whose selector is 7 (flag register) raises `flag_ld` instead of `rf_we`. Every other selector raises `rf_we` and never `flag_ld`.
- R6: Increment (`cmd_op` = 2) and decrement (`cmd_op` = 3) change `sp` by one at the end of the first busy cycle. They raise none of `mem_we`, `mem_re`, `rf_we` or `flag_ld`.
- R7: `sp` wraps modulo 256: decrementing 0x00 gives 0xFF, and incrementing 0xFF gives 0x00.
- R8: The selector encoding is 0 general register, 1 X page, 2 X high, 3 X low, 4 Y page, 5 Y high, 6 Y low, 7 flags. `rf_sel` holds the selector of the accepted command throughout the operation, so a pop may target a register other than the one pushed.
- R9: A series of pushes followed by the same number of pops returns the values in last-in first-out order and restores `sp` to its starting value.
- R10: At most one of `mem_we`, `mem_re`, `rf_we` and `flag_ld` is high in any cycle, and none is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 push, 1 pop, 2 increment SP, 3 decrement SP |
| cmd_sel | input | 3 | Source or destination register selector |
| busy | output | 1 | Engine is executing a command |
| sp | output | 8 | Current stack pointer |
| rf_sel | output | 3 | Register selected for the current command |
| rf_rdata | input | 4 | Read data of the selected register |
| rf_we | output | 1 | Register write strobe (selectors 0 to 6) |
| flag_ld | output | 1 | Flag register load strobe |
| rf_wdata | output | 4 | Data for the register or flag write |
| mem_addr | output | 8 | Data memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 4 | Memory write data |
| mem_rdata | input | 4 | Memory read data (combinational) |

## Verification
Some properties are checked by assertions on every cycle. `sp` moves by at most one per cycle. A memory write always follows a pointer decrement. The pointer rises two cycles after a pop's write strobe. The strobes are mutually exclusive and confined to busy cycles. The command state is held for the whole operation. The flag strobe is used only for selector 7.

Other behaviour only the bench scenarios can show. These are last-in first-out ordering across eight pushes and pops of all selectors, restoring into a different register, wrap-around at 0x00 and 0xFF, and commands ignored while busy. A cycle-level reference model compares every port each cycle during those scenarios.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } stk_op_e;

    localparam logic [2:0] SEL_FLAG = 3'd7;

    // Phase indices inside an operation
    localparam int unsigned PH_A = 0;
    localparam int unsigned PH_B = 1;
    localparam int unsigned PH_C = 2;

    typedef struct packed {
        logic sp_inc;
        logic sp_dec;
        logic cap_src;
        logic cap_mem;
        logic mem_we;
        logic mem_re;
        logic dst_wr;
    } stk_ctl_t;

    function automatic stk_ctl_t stk_decode(stk_op_e op, int unsigned ph);
        stk_ctl_t c;
        c = '0;
        unique case (op)
            OP_PUSH: begin
                c.cap_src = (ph == PH_A);
                c.sp_dec  = (ph == PH_A);
                c.mem_we  = (ph == PH_B);
            end
            OP_POP: begin
                c.mem_re  = (ph == PH_A);
                c.cap_mem = (ph == PH_A);
                c.dst_wr  = (ph == PH_B);
                c.sp_inc  = (ph == PH_C);
            end
            OP_INC: c.sp_inc = (ph == PH_A);
            OP_DEC: c.sp_dec = (ph == PH_A);
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int unsigned SP_W     = 8,
    parameter logic [SP_W-1:0] SP_RESET = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inc,
    input  logic            dec,
    output logic [SP_W-1:0] sp
);

    localparam logic [SP_W-1:0] ONE = SP_W'(1);

    always_ff @(posedge clk) begin
        if (rst)      sp <= SP_RESET;
        else if (inc) sp <= sp + ONE;
        else if (dec) sp <= sp - ONE;
    end

    // R7: pointer moves by at most one step per cycle, modulo 2^SP_W
    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sp == $past(sp)) || (sp == SP_W'($past(sp) + ONE))
                                   || (sp == SP_W'($past(sp) - ONE)));

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int unsigned OP_CYCLES = 5,
    parameter int unsigned SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [SEL_W-1:0] cmd_sel,
    output logic             busy,
    output stk_op_e          op_q,
    output logic [SEL_W-1:0] sel_q,
    output stk_ctl_t         ctl
);

    localparam int unsigned PH_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OP_CYCLES - 1);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            ph_q  <= '0;
            op_q  <= OP_PUSH;
            sel_q <= '0;
        end else if (busy) begin
            if (ph_q == PH_LAST) begin
                busy <= 1'b0;
                ph_q <= '0;
            end else begin
                ph_q <= ph_q + PH_W'(1);
            end
        end else if (cmd_valid) begin
            busy  <= 1'b1;
            ph_q  <= '0;
            op_q  <= stk_op_e'(cmd_op);
            sel_q <= cmd_sel;
        end
    end

    always_comb begin
        ctl = '0;
        if (busy) ctl = stk_decode(op_q, 32'(ph_q));
    end

    // R2: accepted command is held unchanged until the final phase
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && ph_q != PH_LAST) |=> busy && $stable(op_q) && $stable(sel_q));
    // R2: engine releases right after the last phase
    p_release_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && ph_q == PH_LAST) |=> !busy);

endmodule

// File: rtl/stk_engine.sv
module stk_engine
    import stk_pkg::*;
#(
    parameter int unsigned SP_W      = 8,
    parameter int unsigned DATA_W    = 4,
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned OP_CYCLES = 5,
    parameter logic [SP_W-1:0] SP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [SEL_W-1:0]  cmd_sel,
    output logic              busy,
    output logic [SP_W-1:0]   sp,
    output logic [SEL_W-1:0]  rf_sel,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic              flag_ld,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [SP_W-1:0]   mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam logic [SEL_W-1:0] FLAG_SEL = SEL_W'(SEL_FLAG);
    localparam logic [SP_W-1:0]  ONE      = SP_W'(1);

    stk_op_e          op_q;
    logic [SEL_W-1:0] sel_q;
    stk_ctl_t         ctl;
    logic [DATA_W-1:0] data_q;

    stk_seq #(.OP_CYCLES(OP_CYCLES), .SEL_W(SEL_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_sel  (cmd_sel),
        .busy     (busy),
        .op_q     (op_q),
        .sel_q    (sel_q),
        .ctl      (ctl)
    );

    stk_ptr #(.SP_W(SP_W), .SP_RESET(SP_RESET)) u_ptr (
        .clk(clk),
        .rst(rst),
        .inc(ctl.sp_inc),
        .dec(ctl.sp_dec),
        .sp (sp)
    );

    // Transfer nibble: source register for a push, stack top for a pop
    always_ff @(posedge clk) begin
        if (rst)              data_q <= '0;
        else if (ctl.cap_src) data_q <= rf_rdata;
        else if (ctl.cap_mem) data_q <= mem_rdata;
    end

    assign rf_sel    = sel_q;
    assign rf_wdata  = data_q;
    assign rf_we     = ctl.dst_wr && (sel_q != FLAG_SEL);
    assign flag_ld   = ctl.dst_wr && (sel_q == FLAG_SEL);
    assign mem_addr  = sp;
    assign mem_we    = ctl.mem_we;
    assign mem_re    = ctl.mem_re;
    assign mem_wdata = data_q;

    // R3: a memory write always lands one below the previous pointer
    p_push_predec_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (sp == SP_W'($past(sp) - ONE)));
    // R4: pointer rises two cycles after a pop delivers its nibble
    p_pop_postinc_r4: assert property (@(posedge clk) disable iff (rst)
        (rf_we || flag_ld) |=> ##1 (sp == SP_W'($past(sp, 2) + ONE)));
    // R5: flag load only for the flag selector, register write never for it
    p_flag_path_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_ld |-> rf_sel == FLAG_SEL) and (rf_we |-> rf_sel != FLAG_SEL));
    // R10: strobes exclusive and only during an operation
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, mem_re, rf_we, flag_ld}));
    p_strobe_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re || rf_we || flag_ld) |-> busy);

endmodule

// File: tb/stk_engine_bench.sv
module stk_engine_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [2:0] cmd_sel = 3'd0;
    logic       busy, rf_we, flag_ld, mem_we, mem_re;
    logic [7:0] sp, mem_addr;
    logic [2:0] rf_sel;
    logic [3:0] rf_rdata, rf_wdata, mem_wdata, mem_rdata;

    logic [3:0] regs [8];
    logic [3:0] mem [256];

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    stk_engine u_stk_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sel(cmd_sel), .busy(busy), .sp(sp), .rf_sel(rf_sel),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .flag_ld(flag_ld),
        .rf_wdata(rf_wdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Environment: register file and data memory
    assign rf_rdata  = regs[rf_sel];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (rf_we)   regs[rf_sel] <= rf_wdata;
        if (flag_ld) regs[7]      <= rf_wdata;
        if (mem_we)  mem[mem_addr] <= mem_wdata;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge
    bit         m_on = 0;
    bit         m_busy;
    int         m_ph;
    int         m_op;
    int         m_sel;
    logic [7:0] m_sp;
    logic [3:0] m_data;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_on = 1; m_busy = 0; m_ph = 0; m_sp = 8'h00;
        end else if (m_busy) begin
            if (m_ph == 0) begin
                case (m_op)
                    0: begin m_data = regs[m_sel]; m_sp = m_sp - 8'd1; end
                    1: m_data = mem[m_sp];
                    2: m_sp = m_sp + 8'd1;
                    default: m_sp = m_sp - 8'd1;
                endcase
            end else if (m_ph == 2 && m_op == 1) begin
                m_sp = m_sp + 8'd1;
            end
            m_ph++;
            if (m_ph == 5) begin m_busy = 0; m_ph = 0; end
        end else if (cmd_valid) begin
            m_busy = 1; m_ph = 0; m_op = int'(cmd_op); m_sel = int'(cmd_sel);
        end
    end

    // Compare every port against the model each cycle
    always @(negedge clk) begin
        if (m_on) begin
            string mreq;
            bit e_we, e_re, e_rf, e_fl;
            mreq = (m_busy && m_op >= 2) ? "R6" : "R3";
            e_we = m_busy && m_op == 0 && m_ph == 1;
            e_re = m_busy && m_op == 1 && m_ph == 0;
            e_rf = m_busy && m_op == 1 && m_ph == 1 && m_sel != 7;
            e_fl = m_busy && m_op == 1 && m_ph == 1 && m_sel == 7;
            check("R2 busy", int'(busy), int'(m_busy));
            check("R7 sp", int'(sp), int'(m_sp));
            check({mreq, " mem_we"}, int'(mem_we), int'(e_we));
            check("R4 mem_re", int'(mem_re), int'(e_re));
            check("R4 rf_we", int'(rf_we), int'(e_rf));
            check("R5 flag_ld", int'(flag_ld), int'(e_fl));
            check("R10 strobe count", int'($countones({mem_we, mem_re, rf_we, flag_ld})),
                  int'(e_we) + int'(e_re) + int'(e_rf) + int'(e_fl));
            if (m_busy) check("R8 rf_sel", int'(rf_sel), m_sel);
            if (e_we || e_re) check("R3 mem_addr", int'(mem_addr), int'(m_sp));
            if (e_we) check("R3 mem_wdata", int'(mem_wdata), int'(m_data));
            if (e_rf || e_fl) check("R4 rf_wdata", int'(rf_wdata), int'(m_data));
        end
    end

    task automatic run_cmd(int op, int sel, int hold);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_sel = 3'(sel);
        @(negedge clk);
        if (hold > 0) begin
            cmd_op = 2'd2;
            repeat (hold) @(negedge clk);
        end
        cmd_valid = 1'b0;
        repeat (5 - hold) @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] q[$];
        for (int i = 0; i < 256; i++) mem[i] = 4'h0;
        for (int i = 0; i < 8; i++) regs[i] = 4'(i + 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset sp", int'(sp), 0);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset strobes", int'({mem_we, mem_re, rf_we, flag_ld}), 0);

        run_cmd(3, 0, 0);
        check("R7 dec wraps 00->FF", int'(sp), 8'hFF);
        run_cmd(2, 0, 0);
        check("R6 inc back to 00", int'(sp), 8'h00);

        for (int s = 0; s < 8; s++) begin
            q.push_back(regs[s]);
            run_cmd(0, s, 0);
        end
        check("R3 sp after 8 pushes", int'(sp), 8'hF8);
        check("R3 first push stored at FF", int'(mem[8'hFF]), 3);
        check("R3 flag push stored at F8", int'(mem[8'hF8]), 10);

        @(negedge clk);
        for (int i = 0; i < 8; i++) regs[i] = 4'hF;
        for (int s = 7; s >= 0; s--) begin
            logic [3:0] exp;
            exp = q.pop_back();
            run_cmd(1, s, 0);
            check((s == 7) ? "R5 flag restored" : "R9 LIFO value", int'(regs[s]), int'(exp));
        end
        check("R9 sp restored", int'(sp), 8'h00);

        run_cmd(0, 0, 0);
        run_cmd(1, 6, 0);
        check("R8 cross-register restore", int'(regs[6]), int'(regs[0]));

        run_cmd(0, 2, 3);
        check("R2 commands while busy ignored", int'(sp), 8'hFF);
        run_cmd(1, 4, 0);
        check("R2 pop after ignored cmds", int'(regs[4]), int'(regs[2]));
        check("R7 sp back to 00", int'(sp), 8'h00);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule